// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block resolves the conditional-branch opcode family of a 16-bit processor with 10-bit instruction words. Each cycle in which a request is presented, it takes the branch opcode, the displacement word stored after it, the address of the instruction that follows the displacement, the four arithmetic flags (sign, zero, overflow, carry) and four external condition inputs. It returns whether the branch is taken, the branch target, and the program counter the core should fetch from next.

Within the opcode, a three-bit code picks one of eight flag tests and a fourth bit inverts it. A separate mode bit replaces the flag test with an equality test against the external inputs. A direction bit picks a forward or a backward displacement. All results are registered, so they appear one clock after the request. Fetch timing and flag generation belong to the surrounding core.

Top module: `branch_resolve`

## Requirements
- R1: Outputs are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: A synchronous active-high `rst` clears `out_valid`, `taken`, `target` and `new_pc` to zero at the next clock edge.
- R3: Only opcodes whose bits [9:6] equal 4'b1000 (0x200 to 0x23F) belong to the family. For any other opcode, `taken` is 0 and `new_pc` equals `next_pc`.
- R4: The opcode fields are fixed by position: bit 5 is direction, bit 4 selects external-input mode, bit 3 inverts the test, and bits [2:0] are the condition code.
- R5: In flag mode with bit 3 clear, condition codes 0 to 7 are taken when, in order: always; C; O; not S; Z; S xor O; Z or (S xor O); S xor C.
- R6: In flag mode with bit 3 set, each code gives the complement of its R5 test. Code 0 is then never taken.
- R7: In external-input mode (bit 4 set), the branch is taken exactly when `ext_pins` equals opcode bits [3:0]. The flags have no effect.
- R8: With bit 5 clear, `target` is `next_pc + disp` modulo 2^16.
- R9: With bit 5 set, `target` is `next_pc - disp - 1` modulo 2^16.
- R10: `new_pc` equals `target` when the branch is taken, and equals `next_pc` otherwise.
- R11: In a cycle after `in_valid` was low, `taken` is 0 and `target` and `new_pc` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 10 | Instruction word under test |
| disp | input | 16 | Displacement word following the opcode |
| next_pc | input | 16 | Address just past the displacement word |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_o | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| ext_pins | input | 4 | External condition inputs |
| out_valid | output | 1 | Result strobe, one cycle after request |
| taken | output | 1 | Branch decision |
| target | output | 16 | Computed branch destination |
| new_pc | output | 16 | Next fetch address |

## Verification
The bench drives all 64 family opcodes against all 16 flag combinations, and every external-mode opcode against all 16 input values. A design that swapped a condition code, or inverted the wrong sense, would show up as a wrong `taken` on specific code and flag pairs. Backward targets are checked with zero displacement and across the address wrap. An off-by-one in the backward subtraction would move `target` by one word, and a missed carry would land far from the expected address. Opcodes just outside the family, and idle cycles with changing inputs, catch a decoder that matches too loosely or outputs that move while idle.

// File: rtl/bre_pkg.sv
package bre_pkg;

  typedef enum logic [2:0] {
    CC_ALWAYS   = 3'd0,
    CC_CARRY    = 3'd1,
    CC_OVFL     = 3'd2,
    CC_PLUS     = 3'd3,
    CC_EQUAL    = 3'd4,
    CC_LESS     = 3'd5,
    CC_LESS_EQ  = 3'd6,
    CC_SGN_CRY  = 3'd7
  } cond_code_e;

  typedef struct packed {
    logic       dir_back;
    logic       ext_mode;
    logic       negate;
    cond_code_e code;
  } bfield_t;

  typedef struct packed {
    logic s;
    logic z;
    logic o;
    logic c;
  } flags_t;

  localparam int KEY_W = 4;

endpackage

// File: rtl/br_field_decode.sv
module br_field_decode
  import bre_pkg::*;
#(
  parameter int OPC_W = 10,
  parameter int TAG_W = OPC_W - 6,
  parameter logic [TAG_W-1:0] FAM_TAG = {1'b1, {(TAG_W-1){1'b0}}}
) (
  input  logic [OPC_W-1:0] opcode,
  output logic             is_family,
  output bfield_t          fields
);

  assign is_family       = (opcode[OPC_W-1:6] == FAM_TAG);
  assign fields.dir_back = opcode[5];
  assign fields.ext_mode = opcode[4];
  assign fields.negate   = opcode[3];
  assign fields.code     = cond_code_e'(opcode[2:0]);

endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import bre_pkg::*;
#(
  parameter int EXT_W = 4
) (
  input  bfield_t          fields,
  input  flags_t           flags,
  input  logic [EXT_W-1:0] ext_pins,
  output logic             hit
);

  logic             flag_raw;
  logic             ext_hit;
  logic [KEY_W-1:0] key;

  assign key = {fields.negate, fields.code};

  always_comb begin
    unique case (fields.code)
      CC_ALWAYS:  flag_raw = 1'b1;
      CC_CARRY:   flag_raw = flags.c;
      CC_OVFL:    flag_raw = flags.o;
      CC_PLUS:    flag_raw = ~flags.s;
      CC_EQUAL:   flag_raw = flags.z;
      CC_LESS:    flag_raw = flags.s ^ flags.o;
      CC_LESS_EQ: flag_raw = flags.z | (flags.s ^ flags.o);
      CC_SGN_CRY: flag_raw = flags.s ^ flags.c;
      default:    flag_raw = 1'b0;
    endcase
  end

  generate
    if (EXT_W == KEY_W) begin : g_ext_eq
      assign ext_hit = (ext_pins == key);
    end else if (EXT_W > KEY_W) begin : g_ext_wide
      assign ext_hit = (ext_pins == {{(EXT_W-KEY_W){1'b0}}, key});
    end else begin : g_ext_narrow
      assign ext_hit = (ext_pins == key[EXT_W-1:0]);
    end
  endgenerate

  assign hit = fields.ext_mode ? ext_hit : (flag_raw ^ fields.negate);

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int ADDR_W = 16
) (
  input  logic              dir_back,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);

  logic [ADDR_W-1:0] offset;

  // Backward: base - disp - 1 equals base + ~disp in two's complement.
  assign offset = dir_back ? ~disp : disp;
  assign target = base + offset;

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import bre_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OPC_W  = 10,
  parameter int EXT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              flag_s,
  input  logic              flag_z,
  input  logic              flag_o,
  input  logic              flag_c,
  input  logic [EXT_W-1:0]  ext_pins,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] new_pc
);

  logic              is_family;
  bfield_t           fields;
  flags_t            flags;
  logic              cond_hit;
  logic              take_d;
  logic [ADDR_W-1:0] target_d;

  assign flags = '{s: flag_s, z: flag_z, o: flag_o, c: flag_c};

  br_field_decode #(.OPC_W(OPC_W)) u_decode (
    .opcode    (opcode),
    .is_family (is_family),
    .fields    (fields)
  );

  br_cond_eval #(.EXT_W(EXT_W)) u_cond (
    .fields   (fields),
    .flags    (flags),
    .ext_pins (ext_pins),
    .hit      (cond_hit)
  );

  br_target_calc #(.ADDR_W(ADDR_W)) u_target (
    .dir_back (fields.dir_back),
    .base     (next_pc),
    .disp     (disp),
    .target   (target_d)
  );

  assign take_d = is_family & cond_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      target    <= '0;
      new_pc    <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      taken     <= take_d;
      target    <= target_d;
      new_pc    <= take_d ? target_d : next_pc;
    end else begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
    end
  end

endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int ADDR_W = 16,
  parameter int OPC_W  = 10,
  parameter int EXT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] next_pc,
  input logic [EXT_W-1:0]  ext_pins,
  input logic              out_valid,
  input logic              taken,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] new_pc
);

  localparam int TAG_W = OPC_W - 6;
  localparam logic [TAG_W-1:0] FAM = {1'b1, {(TAG_W-1){1'b0}}};

  logic fam;
  assign fam = (opcode[OPC_W-1:6] == FAM);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reset_clears_R2: assert property (@(posedge clk)
    rst |=> (!out_valid && !taken && target == '0 && new_pc == '0));
  assert_outside_family_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fam) |=> !taken);
  assert_always_code_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fam && opcode[4:0] == 5'b00000) |=> taken);
  assert_never_code_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fam && opcode[4:0] == 5'b01000) |=> !taken);
  assert_ext_match_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fam && opcode[4] && ext_pins == EXT_W'(opcode[3:0])) |=> taken);
  assert_taken_pc_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken) |-> (new_pc == target));
  assert_fallthrough_pc_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fam) |=> (new_pc == $past(next_pc)));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(target) && $stable(new_pc) && !taken));

endmodule

bind branch_resolve branch_resolve_chk #(
  .ADDR_W(ADDR_W), .OPC_W(OPC_W), .EXT_W(EXT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .next_pc   (next_pc),
  .ext_pins  (ext_pins),
  .out_valid (out_valid),
  .taken     (taken),
  .target    (target),
  .new_pc    (new_pc)
);

// File: tb/tb_branch_resolve.sv
module tb_branch_resolve;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  opcode = '0;
  logic [15:0] disp = '0;
  logic [15:0] next_pc = '0;
  logic        flag_s = 1'b0, flag_z = 1'b0, flag_o = 1'b0, flag_c = 1'b0;
  logic [3:0]  ext_pins = '0;
  logic        out_valid, taken;
  logic [15:0] target, new_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  bit          m_valid = 0, m_taken = 0;
  logic [15:0] m_target = '0, m_newpc = '0;

  always #5 clk = ~clk;

  branch_resolve dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .disp(disp),
    .next_pc(next_pc), .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o),
    .flag_c(flag_c), .ext_pins(ext_pins), .out_valid(out_valid),
    .taken(taken), .target(target), .new_pc(new_pc)
  );

  function automatic bit ref_taken(int op, bit s, bit z, bit o, bit c, int x);
    bit t;
    if (((op >> 6) & 15) != 8) return 0;
    if ((op >> 4) & 1) return (x == (op & 15));
    case (op & 7)
      0: t = 1;
      1: t = c;
      2: t = o;
      3: t = !s;
      4: t = z;
      5: t = s ^ o;
      6: t = z | (s ^ o);
      default: t = s ^ c;
    endcase
    if ((op >> 3) & 1) t = !t;
    return t;
  endfunction

  function automatic logic [15:0] ref_target(int op, int npc, int d);
    int r;
    if ((op >> 5) & 1) r = npc - d - 1;
    else r = npc + d;
    return 16'(r & 65535);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (out_valid !== m_valid || taken !== m_taken ||
        target !== m_target || new_pc !== m_newpc) begin
      errors++;
      $display("FAIL %s op=%h: actual v=%0b t=%0b tgt=%h pc=%h expected v=%0b t=%0b tgt=%h pc=%h",
               tag, opcode, out_valid, taken, target, new_pc,
               m_valid, m_taken, m_target, m_newpc);
    end
  endtask

  task automatic drive(string tag, bit v, int op, int d, int npc, int f, int x);
    bit t;
    @(negedge clk);
    in_valid = v;
    opcode   = 10'(op);
    disp     = 16'(d);
    next_pc  = 16'(npc);
    {flag_s, flag_z, flag_o, flag_c} = 4'(f);
    ext_pins = 4'(x);
    @(posedge clk);
    #1;
    if (v) begin
      t = ref_taken(op, f[3], f[2], f[1], f[0], x);
      m_valid  = 1;
      m_taken  = t;
      m_target = ref_target(op, npc, d);
      m_newpc  = t ? m_target : 16'(npc);
    end else begin
      m_valid = 0;
      m_taken = 0;
    end
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R2 reset");
    @(negedge clk);
    rst = 1'b0;

    // R1: latency and strobe
    drive("R1 valid", 1, 'h200, 'h0040, 'h1000, 0, 0);
    drive("R1 idle", 0, 'h205, 'h1111, 'h2222, 15, 3);

    // R4: field positions
    drive("R4 dir", 1, 'h220, 'h0010, 'h1000, 0, 0);
    drive("R4 ext", 1, 'h218, 'h0003, 'h0100, 0, 8);
    drive("R4 neg", 1, 'h208, 'h0003, 'h0100, 0, 0);

    // sweep all family opcodes against all flag combinations
    for (int op = 'h200; op < 'h240; op++) begin
      for (int f = 0; f < 16; f++) begin
        string tg;
        if (op & 'h10) tg = "R7 ext";
        else if (op & 'h8) tg = "R6 inverted";
        else tg = "R5 direct";
        drive(tg, 1, op, $urandom & 65535, $urandom & 65535, f, $urandom & 15);
      end
    end

    // R7: every external value against every external-mode opcode
    for (int op = 'h210; op < 'h240; op++) begin
      if ((op & 'h10) == 0) continue;
      for (int x = 0; x < 16; x++)
        drive("R7 pins", 1, op, $urandom & 65535, $urandom & 65535, $urandom & 15, x);
    end

    // R8 / R9: arithmetic corners
    drive("R8 wrap", 1, 'h200, 'h0020, 'hFFF0, 0, 0);
    drive("R8 zero", 1, 'h200, 'h0000, 'h4000, 0, 0);
    drive("R9 wrap", 1, 'h220, 'h0010, 'h0005, 0, 0);
    drive("R9 zero", 1, 'h220, 'h0000, 'h4000, 0, 0);
    drive("R9 max", 1, 'h220, 'hFFFF, 'h0000, 0, 0);

    // R3: just outside the family, all flags set
    drive("R3 below", 1, 'h1FF, 'h0010, 'h3000, 15, 15);
    drive("R3 above", 1, 'h240, 'h0010, 'h3000, 15, 0);
    drive("R3 high", 1, 'h3C0, 'h0010, 'h3000, 15, 0);
    drive("R3 zero", 1, 'h000, 'h0010, 'h3000, 15, 0);

    // R10: not taken keeps fall-through address, taken uses target
    drive("R10 fall", 1, 'h201, 'h0100, 'h5000, 0, 0);
    drive("R10 take", 1, 'h201, 'h0100, 'h5000, 1, 0);

    // R11: idle cycles with moving inputs hold state
    drive("R11 idle1", 0, 'h200, 'h7777, 'h0001, 15, 15);
    drive("R11 idle2", 0, 'h228, 'h1234, 'h9999, 0, 5);
    drive("R1 resume", 1, 'h204, 'h0002, 'h0010, 4, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule